// File: doc/BRIEF.md
# SPI Master Controller with Competing-Master Detection

This block is an 8-bit serial peripheral interface master with a small register-style host port. The host writes a control byte, a clock-rate byte and a transmit byte, and reads a status byte and the received byte. Once started, a frame shifts eight bits out on the data-out pin and eight bits in from the data-in pin. The serial clock is built from the system clock by a programmable divider. Clock polarity, sampling phase and bit order can each be selected.

The select pin has two uses. It can be a chip-select output that is low for the whole frame. It can also be an input that watches for another master on the bus. A low level on that input forces the block out of master mode at once. The block then releases every output it drives, drops any frame in flight, and sets a fault flag that can raise an interrupt. Changing any timing or format setting while a frame is running also drops the frame and returns the block to idle.

Register map (addr): 0 = control, 1 = clock rate, 2 = status, 3 = data (write: transmit byte, read: received byte). The control byte holds: bit 0 master enable, bit 1 clock idle level, bit 2 phase, bit 3 LSB-first, bit 4 select-drive enable, bit 5 fault-detect enable, bit 6 interrupt enable, and bit 7 always reads 0. The rate byte holds the preselect P in bits 6:4 and the exponent E in bits 3:0. The status byte has receive-full in bit 7, transmit-empty in bit 5 and fault in bit 4; all other bits read 0.

Top module: `spim_master`

## Requirements
- R1: After reset, control and rate read 0x00, status reads 0x20, sck_oe, mosi_oe and ss_oe are 0, ss_o is 1 and irq is 0.
- R2: While control bit 0 is clear, sck_oe, mosi_oe and ss_oe are 0, and a write to the data register starts no frame (no serial clock edge, ss_o stays 1).
- R3: A data write starts a frame only if the previous access to the data register was followed by a status read that saw bit 5 set. A data write without such a read is ignored. When the shifter is idle, the byte enters it at once and status bit 5 reads 1 again on the next access.
- R4: The serial clock half period is H = (P+1)·2^E system clocks. The first clock edge comes exactly H cycles after the clock edge that accepts the data write, each following edge comes H cycles after the one before it, and a frame has 16 edges.
- R5: While idle, sck_o equals control bit 1. With bit 2 clear, bits are sampled on odd edges and shifted on even edges. With bit 2 set, bits are shifted on odd edges from the third onward and sampled on even edges. Bits go MSB-first, or LSB-first when bit 3 is set.
- R6: Status bit 7 sets when the frame ends, and the data register then returns the eight bits sampled from miso_i. A status read that sees bit 7 set, followed by a data read, clears it.
- R7: With control bits 0, 4 and 5 set, ss_oe is 1 and ss_o is low for the whole frame and high when idle; ss_i is ignored in this setting.
- R8: With bits 0 and 5 set and bit 4 clear, ss_i low clears bit 0, drops sck_oe and mosi_oe, ends any frame without setting bit 7, and sets status bit 4.
- R9: irq is high exactly while status bit 4 and control bit 6 are both set.
- R10: Status bit 4 is cleared only by a control write that follows a status read which saw it set; a control write without that read leaves it set.
- R11: A control write that changes bit 1, 2, 3, 4 or 5 or clears bit 0, or a rate write that changes the rate, aborts a running frame at once (ss_o high, sck_o at idle level, bit 7 not set). A control write with unchanged values does not abort.
- R12: A byte written while a frame runs is held (status bit 5 reads 0) and starts the next frame at the end of the current one, with no idle gap, giving 32 edges in all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| sck_o | output | 1 | Serial clock value |
| sck_oe | output | 1 | Serial clock driver enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out driver enable |
| miso_i | input | 1 | Serial data in |
| ss_o | output | 1 | Select output value (low during a frame) |
| ss_oe | output | 1 | Select output driver enable |
| ss_i | input | 1 | Select input, watched for a competing master |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches properties on every cycle. A detected fault must release all drivers and set the flag on the next cycle, and must raise irq when enabled. The clock must rest at its idle level whenever no frame runs. The edge count must never pass the frame length. The select output must go low right after a start, an abort must leave the block idle, and receive-full may rise only at a frame end. The exact half-period arithmetic and the bit order for every phase, polarity and order setting can only be shown by the bench's sweep, which compares the shifted bits and the edge times against values it computes itself. The same holds for the status-read-then-access handshakes and the back-to-back hand-over.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 3;
  localparam int RATE_W = 4;
  localparam int HALF_W = PRE_W + 2**RATE_W;
  localparam int EDGES  = 2 * BYTE_W;
  localparam int EDGE_W = $clog2(EDGES + 1);

  localparam int ST_RXF  = 7;
  localparam int ST_TXE  = 5;
  localparam int ST_MODF = 4;

  typedef enum logic [1:0] {A_CTRL = 2'd0, A_BAUD = 2'd1, A_STAT = 2'd2, A_DATA = 2'd3} reg_addr_e;

  typedef struct packed {
    logic spare;
    logic irq_en;
    logic fault_en;
    logic ss_drive;
    logic lsb_first;
    logic cpha;
    logic cpol;
    logic master;
  } ctrl_t;

  // half serial-clock period in system clocks
  function automatic logic [HALF_W-1:0] half_period(input logic [PRE_W-1:0] pre,
                                                   input logic [RATE_W-1:0] rate);
    return (HALF_W'(pre) + HALF_W'(1)) << rate;
  endfunction

  // edge k (1-based) captures data-in
  function automatic logic is_sample(input logic [EDGE_W-1:0] k, input logic cpha);
    return k[0] ^ cpha;
  endfunction

  // edge k (1-based) moves the next bit onto data-out
  function automatic logic is_launch(input logic [EDGE_W-1:0] k, input logic cpha);
    return !is_sample(k, cpha) && (k >= (cpha ? EDGE_W'(3) : EDGE_W'(2)))
           && (k < EDGE_W'(EDGES));
  endfunction
endpackage

// File: rtl/spim_baud.sv
`timescale 1ns/1ps
module spim_baud
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;

  assign tick = run && (cnt == half - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + HALF_W'(1);
  end
endmodule

// File: rtl/spim_shift.sv
`timescale 1ns/1ps
module spim_shift
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              abort,
  input  logic              tick,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              miso,
  output logic              mosi,
  output logic              ph,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_nxt,
  output logic [EDGE_W-1:0] edge_cnt
);
  logic [BYTE_W-1:0] txsr, rxsr;
  logic [EDGE_W-1:0] k;
  logic              step, samp, launch;

  assign k      = edge_cnt + EDGE_W'(1);
  assign step   = tick && busy;
  assign samp   = step && is_sample(k, cpha);
  assign launch = step && is_launch(k, cpha);
  assign done   = step && (k == EDGE_W'(EDGES));
  assign mosi   = lsb_first ? txsr[0] : txsr[BYTE_W-1];

  always_comb begin
    rx_nxt = rxsr;
    if (samp) rx_nxt = lsb_first ? {miso, rxsr[BYTE_W-1:1]} : {rxsr[BYTE_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ph <= 1'b0; edge_cnt <= '0; txsr <= '0; rxsr <= '0;
    end else if (abort) begin
      busy <= 1'b0; ph <= 1'b0; edge_cnt <= '0;
    end else if (load) begin
      busy <= 1'b1; ph <= 1'b0; edge_cnt <= '0; txsr <= load_byte; rxsr <= '0;
    end else if (step) begin
      ph       <= ~ph;
      edge_cnt <= k;
      rxsr     <= rx_nxt;
      if (launch) txsr <= lsb_first ? (txsr >> 1) : (txsr << 1);
      if (done) begin
        busy     <= 1'b0;
        ph       <= 1'b0;
        edge_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/spim_master.sv
`timescale 1ns/1ps
module spim_master
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              ss_o,
  output logic              ss_oe,
  input  logic              ss_i,
  output logic              irq
);
  ctrl_t                    ctrl_q, ctrl_w;
  logic [PRE_W+RATE_W-1:0]  baud_q;
  logic [BYTE_W-1:0]        rx_data, tx_buf, rx_nxt, load_byte;
  logic                     tx_empty, rx_full, modf, pend;
  logic                     arm_tx, arm_rx, arm_modf;
  logic                     rd_stat, rd_data, wr_ctrl, wr_baud, wr_data;
  logic                     mode_fault, cfg_change, data_ok;
  logic                     xfer_start, xfer_done, xfer_abort, raw_done;
  logic                     busy, tick, ph, mosi;
  logic [EDGE_W-1:0]        edge_cnt;
  logic [HALF_W-1:0]        half;

  assign rd_stat = rd_en && (addr == A_STAT);
  assign rd_data = rd_en && (addr == A_DATA);
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_baud = wr_en && (addr == A_BAUD);
  assign wr_data = wr_en && (addr == A_DATA);

  always_comb begin
    ctrl_w       = ctrl_t'(wdata);
    ctrl_w.spare = 1'b0;
  end

  assign half = half_period(baud_q[PRE_W+RATE_W-1:RATE_W], baud_q[RATE_W-1:0]);

  // competing master pulls the select input low
  assign mode_fault = ctrl_q.master && ctrl_q.fault_en && !ctrl_q.ss_drive && !ss_i;

  assign cfg_change = (wr_ctrl && (!ctrl_w.master
                                   || (ctrl_w.cpol      != ctrl_q.cpol)
                                   || (ctrl_w.cpha      != ctrl_q.cpha)
                                   || (ctrl_w.lsb_first != ctrl_q.lsb_first)
                                   || (ctrl_w.ss_drive  != ctrl_q.ss_drive)
                                   || (ctrl_w.fault_en  != ctrl_q.fault_en)))
                   || (wr_baud && (wdata[PRE_W+RATE_W-1:0] != baud_q));

  assign xfer_abort = busy && (mode_fault || cfg_change);
  assign data_ok    = wr_data && arm_tx && tx_empty && ctrl_q.master && !mode_fault && !cfg_change;
  assign xfer_done  = raw_done && !xfer_abort;
  assign xfer_start = !xfer_abort && ((data_ok && !busy) || (xfer_done && (pend || data_ok)));
  assign load_byte  = pend ? tx_buf : wdata;

  spim_baud u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half), .tick(tick)
  );

  spim_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(xfer_start), .load_byte(load_byte),
    .abort(xfer_abort), .tick(tick), .cpha(ctrl_q.cpha), .lsb_first(ctrl_q.lsb_first),
    .miso(miso_i), .mosi(mosi), .ph(ph), .busy(busy), .done(raw_done),
    .rx_nxt(rx_nxt), .edge_cnt(edge_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; baud_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_w;
      if (wr_baud) baud_q <= wdata[PRE_W+RATE_W-1:0];
      if (mode_fault) ctrl_q.master <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty <= 1'b1; pend <= 1'b0; tx_buf <= '0; arm_tx <= 1'b0;
    end else begin
      if (wr_data || rd_data)      arm_tx <= 1'b0;
      else if (rd_stat && tx_empty) arm_tx <= 1'b1;
      if (xfer_abort) begin
        pend <= 1'b0; tx_empty <= 1'b1;
      end else if (data_ok && busy && !xfer_done) begin
        pend <= 1'b1; tx_empty <= 1'b0; tx_buf <= wdata;
      end else if (xfer_done && pend) begin
        pend <= 1'b0; tx_empty <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0; rx_data <= '0; arm_rx <= 1'b0; modf <= 1'b0; arm_modf <= 1'b0;
    end else begin
      if (rd_data)                arm_rx <= 1'b0;
      else if (rd_stat && rx_full) arm_rx <= 1'b1;
      if (xfer_done) begin
        rx_full <= 1'b1; rx_data <= rx_nxt;
      end else if (rd_data && arm_rx) begin
        rx_full <= 1'b0;
      end
      if (wr_ctrl)              arm_modf <= 1'b0;
      else if (rd_stat && modf) arm_modf <= 1'b1;
      if (mode_fault)                modf <= 1'b1;
      else if (wr_ctrl && arm_modf) modf <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata = ctrl_q;
      A_BAUD: rdata = BYTE_W'(baud_q);
      A_STAT: begin
        rdata[ST_RXF]  = rx_full;
        rdata[ST_TXE]  = tx_empty;
        rdata[ST_MODF] = modf;
      end
      default: rdata = rx_data;
    endcase
  end

  assign sck_o   = ctrl_q.cpol ^ ph;
  assign sck_oe  = ctrl_q.master;
  assign mosi_o  = mosi;
  assign mosi_oe = ctrl_q.master;
  assign ss_oe   = ctrl_q.master && ctrl_q.fault_en && ctrl_q.ss_drive;
  assign ss_o    = !busy;
  assign irq     = ctrl_q.irq_en && modf;
endmodule

// File: rtl/spim_master_chk.sv
`timescale 1ns/1ps
module spim_master_chk
  import spim_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_fault,
  input logic              xfer_start,
  input logic              xfer_done,
  input logic              xfer_abort,
  input logic              busy,
  input logic [EDGE_W-1:0] edge_cnt,
  input logic              sck_o,
  input logic              sck_oe,
  input logic              mosi_oe,
  input logic              ss_o,
  input logic              ss_oe,
  input logic              irq,
  input logic              irq_en,
  input logic              cpol,
  input logic              modf,
  input logic              rx_full,
  input logic              wr_ctrl
);
  // R8: a fault releases every driver and raises the flag one cycle later
  p_fault_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |=> (!sck_oe && !mosi_oe && !ss_oe && modf && !busy));

  // R9: enabled fault requests an interrupt
  p_fault_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fault && irq_en && !wr_ctrl) |=> irq);

  // R5: clock rests at its idle level outside a frame
  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck_o == cpol));

  // R4: a frame never exceeds its edge count
  p_edge_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (edge_cnt < EDGE_W'(EDGES)));

  // R7: select goes low right after a start
  p_ss_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !ss_o);

  // R11: an abort leaves the block idle
  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |=> !busy);

  // R6: receive-full rises only at a frame end
  p_rxfull_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(xfer_done));
endmodule

bind spim_master spim_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_fault(mode_fault), .xfer_start(xfer_start),
  .xfer_done(xfer_done), .xfer_abort(xfer_abort), .busy(busy), .edge_cnt(edge_cnt),
  .sck_o(sck_o), .sck_oe(sck_oe), .mosi_oe(mosi_oe), .ss_o(ss_o), .ss_oe(ss_oe),
  .irq(irq), .irq_en(ctrl_q.irq_en), .cpol(ctrl_q.cpol), .modf(modf),
  .rx_full(rx_full), .wr_ctrl(wr_ctrl)
);

// File: tb/spim_master_test.sv
`timescale 1ns/1ps
module spim_master_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, ss_o, ss_oe, irq;
  logic       miso_i = 1'b0, ss_i = 1'b1;

  int n_chk = 0, n_err = 0, cyc = 0, wcyc = 0;
  int tog = 0, sidx = 0;
  int tcyc [0:63];
  bit mon_on = 0, cur_cpha = 0, cur_lsb = 0, finished = 0;
  logic [7:0] got = '0, sbyte = '0, s = '0;

  localparam logic [1:0] CTRL = 2'd0, BAUD = 2'd1, STAT = 2'd2, DATA = 2'd3;

  spim_master uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .ss_o(ss_o), .ss_oe(ss_oe), .ss_i(ss_i), .irq(irq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  function automatic int bpos(input int i, input bit lsb);
    return lsb ? i : 7 - i;
  endfunction

  function automatic logic [7:0] mk(input bit m, cpol, cpha, lsb, ssd, flt, ie);
    return {1'b0, ie, flt, ssd, lsb, cpha, cpol, m};
  endfunction

  // bench-side slave: captures data-out on sampling edges, presents next data-in bit
  always @(sck_o) begin
    if (mon_on) begin
      tog = tog + 1;
      if (tog < 64) tcyc[tog] = cyc;
      if ((tog % 2 == 1) != cur_cpha) begin
        if (sidx < 8) got[bpos(sidx, cur_lsb)] = mosi_o;
        sidx = sidx + 1;
        if (sidx < 8) miso_i = sbyte[bpos(sidx, cur_lsb)];
      end
      if (tog % 16 == 0) begin
        sidx = 0;
        miso_i = sbyte[bpos(0, cur_lsb)];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; wcyc = cyc;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mon_start(input logic [7:0] sb, input bit cpha, input bit lsb);
    tog = 0; sidx = 0; got = '0; sbyte = sb; cur_cpha = cpha; cur_lsb = lsb;
    miso_i = sb[bpos(0, lsb)]; mon_on = 1;
  endtask

  task automatic start(input logic [7:0] tx);
    logic [7:0] st;
    rd(STAT, st);
    wr(DATA, tx);
  endtask

  task automatic xfer(input bit cpol, cpha, lsb, input int p, r, input logic [7:0] tx, sx);
    int h;
    bit tok;
    logic [7:0] st, d;
    h = (p + 1) << r;
    wr(CTRL, mk(1, cpol, cpha, lsb, 0, 0, 0));
    wr(BAUD, 8'((p << 4) | r));
    mon_start(sx, cpha, lsb);
    start(tx);
    idle(16 * h + 4);
    chk(tog == 16, "R4 edge count", tog, 16);
    tok = (tcyc[1] - wcyc) == h;
    for (int k = 2; k <= 16; k++) if (tcyc[k] - tcyc[k-1] != h) tok = 0;
    chk(tok, "R4 half period", tcyc[1] - wcyc, h);
    chk(got == tx, "R5 bits out", got, tx);
    chk(sck_o == cpol, "R5 idle level", sck_o, cpol);
    rd(STAT, st);
    chk(st[7] == 1'b1, "R6 rx full set", st, 8'ha0);
    rd(DATA, d);
    chk(d == sx, "R6 rx byte", d, sx);
    rd(STAT, st);
    chk(st[7] == 1'b0, "R6 rx full cleared", st, 8'h20);
    mon_on = 0;
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int t;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(CTRL, s); chk(s == 8'h00, "R1 ctrl", s, 0);
    rd(BAUD, s); chk(s == 8'h00, "R1 baud", s, 0);
    rd(STAT, s); chk(s == 8'h20, "R1 status", s, 8'h20);
    chk({sck_oe, mosi_oe, ss_oe, irq} == 4'b0 && ss_o, "R1 outputs", {sck_oe, mosi_oe, ss_oe, irq, ss_o}, 1);

    // R2 master off: data write starts nothing
    mon_start(8'h00, 0, 0);
    start(8'h3c);
    idle(10);
    chk(tog == 0 && ss_o == 1'b1, "R2 no frame when not master", tog, 0);
    chk({sck_oe, mosi_oe, ss_oe} == 3'b0, "R2 drivers off", {sck_oe, mosi_oe, ss_oe}, 0);

    // R3 data write without prior status read is ignored
    wr(CTRL, mk(1, 0, 0, 0, 0, 0, 0));
    wr(BAUD, 8'h00);
    mon_start(8'h96, 0, 0);
    wr(DATA, 8'h5a);
    idle(10);
    chk(tog == 0, "R3 unarmed write ignored", tog, 0);
    start(8'h5a);
    rd(STAT, s);
    chk(s[5] == 1'b1, "R3 tx empty again", s, 8'h20);
    idle(20);
    chk(tog == 16 && got == 8'h5a, "R3 armed write starts frame", got, 8'h5a);
    rd(STAT, s); rd(DATA, s);
    chk(s == 8'h96, "R3 rx of frame", s, 8'h96);
    mon_on = 0;

    // R4 R5 R6 sweep: preselect, exponent, phase, polarity, order
    for (int p = 0; p < 3; p++)
      for (int r = 0; r < 3; r++)
        for (int m = 0; m < 4; m++)
          for (int l = 0; l < 2; l++) begin
            logic [7:0] tx, sx;
            tx = 8'(8'ha5 ^ ((p * 24 + r * 8 + m * 2 + l) * 37));
            sx = {tx[2:0], ~tx[7:3]};
            xfer(m[1], m[0], l[0], p, r, tx, sx);
          end

    // R7 select output framing
    wr(CTRL, mk(1, 0, 0, 0, 1, 1, 0));
    wr(BAUD, 8'h11);
    chk(ss_oe == 1'b1 && ss_o == 1'b1, "R7 select idle high", {ss_oe, ss_o}, 3);
    mon_start(8'h0f, 0, 0);
    start(8'hf0);
    idle(6);
    chk(ss_o == 1'b0, "R7 select low in frame", ss_o, 0);
    ss_i = 1'b0;
    idle(4);
    rd(CTRL, s);
    chk(s[0] == 1'b1 && sck_oe, "R7 select input ignored", s, 8'h31);
    ss_i = 1'b1;
    idle(70);
    chk(ss_o == 1'b1 && tog == 16, "R7 select high after frame", tog, 16);
    rd(STAT, s); chk(s[4] == 1'b0, "R7 no fault flag", s, 8'ha0);
    rd(DATA, s);
    mon_on = 0;

    // R12 back-to-back frames
    wr(CTRL, mk(1, 0, 0, 0, 1, 1, 0));
    wr(BAUD, 8'h01);
    mon_start(8'hc3, 0, 0);
    start(8'h11);
    start(8'h22);
    rd(STAT, s);
    chk(s[5] == 1'b0, "R12 held byte clears tx empty", s, 0);
    idle(80);
    chk(tog == 32, "R12 edge total", tog, 32);
    chk(tcyc[17] - tcyc[16] == 2, "R12 no idle gap", tcyc[17] - tcyc[16], 2);
    chk(got == 8'h22, "R12 second byte out", got, 8'h22);
    rd(STAT, s);
    chk(s[5] == 1'b1 && s[7] == 1'b1, "R12 status after", s, 8'ha0);
    rd(DATA, s);
    chk(s == 8'hc3, "R12 rx of second frame", s, 8'hc3);
    mon_on = 0;

    // R11 configuration change aborts
    wr(CTRL, mk(1, 0, 0, 0, 1, 1, 0));
    wr(BAUD, 8'h03);
    mon_start(8'h55, 0, 0);
    start(8'h81);
    idle(20);
    wr(CTRL, mk(1, 0, 0, 0, 1, 1, 0));
    idle(4);
    chk(ss_o == 1'b0 && tog > 2, "R11 same value keeps frame", ss_o, 0);
    wr(CTRL, mk(1, 1, 0, 0, 1, 1, 0));
    chk(ss_o == 1'b1 && sck_o == 1'b1, "R11 polarity change aborts", {ss_o, sck_o}, 3);
    t = tog;
    idle(40);
    chk(tog == t, "R11 clock quiet after abort", tog, t);
    rd(STAT, s);
    chk(s[7] == 1'b0 && s[5] == 1'b1, "R11 no rx full", s, 8'h20);
    start(8'h81);
    idle(20);
    wr(BAUD, 8'h02);
    chk(ss_o == 1'b1, "R11 rate change aborts", ss_o, 1);
    rd(STAT, s);
    chk(s[7] == 1'b0, "R11 rate abort no rx", s, 8'h20);
    mon_on = 0;

    // R8 R9 R10 mode fault
    wr(CTRL, mk(1, 0, 0, 0, 0, 1, 1));
    wr(BAUD, 8'h03);
    mon_start(8'h55, 0, 0);
    start(8'h42);
    idle(20);
    ss_i = 1'b0;
    @(negedge clk);
    chk(!sck_oe && !mosi_oe && !ss_oe, "R8 drivers released", {sck_oe, mosi_oe, ss_oe}, 0);
    chk(irq == 1'b1, "R9 irq on fault", irq, 1);
    ss_i = 1'b1;
    rd(CTRL, s);
    chk(s[0] == 1'b0, "R8 master cleared", s, 8'h60);
    t = tog;
    idle(40);
    chk(tog == t, "R8 frame dropped", tog, t);
    wr(CTRL, mk(0, 0, 0, 0, 0, 1, 1));
    rd(STAT, s);
    chk(s[4] == 1'b1, "R10 flag held without status read", s, 8'h30);
    chk(s[7] == 1'b0, "R8 no rx full after fault", s, 8'h30);
    wr(DATA, 8'h42);
    idle(10);
    chk(tog == t, "R8 no frame while not master", tog, t);
    rd(STAT, s);
    wr(CTRL, mk(1, 0, 0, 0, 0, 1, 1));
    rd(STAT, s);
    chk(s[4] == 1'b0, "R10 flag cleared", s, 8'h20);
    chk(irq == 1'b0, "R9 irq follows flag", irq, 0);
    mon_on = 0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule